// File: doc/BRIEF.md
# Addressable Latch with Decoder Mode

This block stores eight bits and writes them one at a time. A single data bit is steered into one of eight storage cells, chosen by a three-bit select. An active-low enable opens the write path. An active-low clear either wipes every cell or, when combined with an active enable, turns the block into a one-hot 3-to-8 decoder whose selected line carries the data bit. All eight cells appear in parallel on the outputs.

The model is synchronous to a system clock. While the enable is active, the selected output shows the live data bit in the same cycle through a combinational path. The stored cell takes the value sampled in each enabled cycle, so after release it keeps the data from the last enabled cycle. A synchronous active-high reset sets all cells to zero; it is separate from the functional clear. Select and data should change only while the enable is inactive.

Top module: `addr_latch`

## Requirements
- R1: The select is an unsigned binary number with bit 2 as the most significant bit, and value k addresses output bit k, so 0 picks bit 0 and 7 picks bit 7.
- R2: With clearN high and enableN low, the addressed output equals dataIn in the same cycle.
- R3: With clearN high and enableN low, every unaddressed output keeps the value it had in the previous cycle.
- R4: When enableN goes from low to high with clearN high, the previously addressed output keeps the dataIn value sampled in the last enabled cycle.
- R5: With clearN high and enableN high, all outputs keep their previous values whatever dataIn and the select do.
- R6: With clearN low and enableN high, all outputs are low in the same cycle, and they remain low after a return to hold mode.
- R7: With clearN low and enableN low, the addressed output equals dataIn and all other outputs are low. This pattern is stored and persists into a following hold cycle.
- R8: A clock edge with rst high sets all stored bits to zero, and this shows on the outputs in the next hold cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the stored bits |
| dataIn | input | 1 | Data bit steered to the addressed cell |
| sel | input | 3 | Binary address of the target cell |
| enableN | input | 1 | Active-low write enable |
| clearN | input | 1 | Active-low clear; with enable active it selects decoder mode |
| latchOut | output | 8 | Parallel view of the eight cells, with the live overlay |

## Verification
A cell with a corrupted stored value stays hidden only while it is addressed in an enabled cycle. It shows up on its own output in the first hold cycle or the first write to a different address, one clock edge after the fault, and it persists until that cell is rewritten or cleared. A wrong select decode shows in the same cycle as the write: the data appears on the wrong bit. A mode decode that swaps clear and decoder shows at once in the pattern of low outputs. The bench tracks a reference copy of all eight cells and compares every output bit every cycle, so any divergence is reported on the cycle it first becomes visible.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  localparam int LATCH_SEL_W = 3;
  localparam int LATCH_N     = 1 << LATCH_SEL_W;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_WIPE   = 2'd3
  } latchMode_t;

  // Per-bit strobes from control to datapath
  typedef struct packed {
    logic [LATCH_N-1:0] loadBit;  // bit takes dataIn
    logic [LATCH_N-1:0] zeroBit;  // bit forced low
  } latchStrobes_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = LATCH_SEL_W,
  localparam int N    = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             enableN,
  input  logic             clearN,
  output latchStrobes_t    strobes
);

  latchMode_t modeNow;
  logic [N-1:0] selOneHot;

  always_comb begin
    unique case ({clearN, enableN})
      2'b10:   modeNow = MODE_WRITE;
      2'b11:   modeNow = MODE_HOLD;
      2'b00:   modeNow = MODE_DECODE;
      default: modeNow = MODE_WIPE;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_dec
      assign selOneHot[gi] = (sel == SEL_W'(gi));
    end
  endgenerate

  always_comb begin
    strobes.loadBit = '0;
    strobes.zeroBit = '0;
    case (modeNow)
      MODE_WRITE: strobes.loadBit = selOneHot;
      MODE_DECODE: begin
        strobes.loadBit = selOneHot;
        strobes.zeroBit = ~selOneHot;
      end
      MODE_WIPE: strobes.zeroBit = '1;
      default: ;
    endcase
  end

endmodule

// File: rtl/addr_latch_datapath.sv
module addr_latch_datapath
  import addr_latch_pkg::*;
#(
  parameter int N = LATCH_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dataIn,
  input  latchStrobes_t strobes,
  output logic [N-1:0]  latchOut
);

  logic [N-1:0] storedBits;
  logic [N-1:0] nextBits;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cell
      always_comb begin
        if (strobes.loadBit[gi])      nextBits[gi] = dataIn;
        else if (strobes.zeroBit[gi]) nextBits[gi] = 1'b0;
        else                          nextBits[gi] = storedBits[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) storedBits <= '0;
    else     storedBits <= nextBits;
  end

  // Transparent view: live data overlays the stored cells
  assign latchOut = nextBits;

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int SEL_W = LATCH_SEL_W,
  localparam int N    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dataIn,
  input  logic [SEL_W-1:0] sel,
  input  logic             enableN,
  input  logic             clearN,
  output logic [N-1:0]     latchOut
);

  latchStrobes_t strobes;

  addr_latch_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .sel     (sel),
    .enableN (enableN),
    .clearN  (clearN),
    .strobes (strobes)
  );

  addr_latch_datapath #(.N(N)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .strobes  (strobes),
    .latchOut (latchOut)
  );

endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int SEL_W = 3,
  localparam int N    = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             dataIn,
  input logic [SEL_W-1:0] sel,
  input logic             enableN,
  input logic             clearN,
  input logic [N-1:0]     latchOut
);

  logic [N-1:0] addrMask;
  assign addrMask = N'(1) << sel;

  // R2
  write_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && !enableN) |-> (latchOut[sel] == dataIn));

  // R3
  write_others_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && !enableN && !$past(rst)) |-> (((latchOut ^ $past(latchOut)) & ~addrMask) == '0));

  // R4
  release_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && enableN && $past(clearN) && !$past(enableN) && !$past(rst))
      |-> (latchOut[$past(sel)] == $past(dataIn)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && enableN && !$past(rst)) |-> $stable(latchOut));

  // R6
  wipe_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!clearN && enableN) |-> (latchOut == '0));

  // R7
  decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!clearN && !enableN) |-> ($countones(latchOut) == int'(dataIn) && latchOut[sel] == dataIn));

  // R8
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && clearN && enableN) |-> (latchOut == '0));

endmodule

bind addr_latch addr_latch_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dataIn   (dataIn),
  .sel      (sel),
  .enableN  (enableN),
  .clearN   (clearN),
  .latchOut (latchOut)
);

// File: tb/addr_latch_test.sv
module addr_latch_test;

  localparam int SW = 3;
  localparam int NB = 1 << SW;

  logic          clk = 1'b0;
  logic          rst;
  logic          dataIn;
  logic [SW-1:0] sel;
  logic          enableN;
  logic          clearN;
  logic [NB-1:0] latchOut;

  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] modelQ = '0;

  always #4 clk = ~clk;  // 125 MHz

  addr_latch uut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .sel(sel),
    .enableN(enableN), .clearN(clearN), .latchOut(latchOut)
  );

  // Expected output from the requirements (R2, R3, R5, R6, R7)
  function automatic logic [NB-1:0] expOut(logic [NB-1:0] q, logic d,
                                           logic [SW-1:0] s, logic en, logic cl);
    logic [NB-1:0] r;
    r = q;
    if (!cl && en)       r = '0;
    else if (!cl && !en) begin r = '0; r[s] = d; end
    else if (cl && !en)  r[s] = d;
    return r;
  endfunction

  function automatic string tagFor(logic en, logic cl);
    if (!cl && en)  return "R6";
    if (!cl && !en) return "R7";
    if (cl && !en)  return "R2/R3";
    return "R5";
  endfunction

  task automatic check(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, compare mid-cycle, then advance the model at posedge
  task automatic step(logic d, logic [SW-1:0] s, logic en, logic cl, string tag = "");
    logic [NB-1:0] e;
    @(negedge clk);
    rst = 1'b0; dataIn = d; sel = s; enableN = en; clearN = cl;
    #1;
    e = expOut(modelQ, d, s, en, cl);
    check((tag == "") ? tagFor(en, cl) : tag, latchOut, e);
    @(posedge clk);
    modelQ = e;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; dataIn = 1'b1; sel = '0; enableN = 1'b0; clearN = 1'b1;
    repeat (2) @(posedge clk);
    modelQ = '0;
    // R8: reset state seen in hold
    step(1'b1, 3'd5, 1'b1, 1'b1, "R8");

    // R1: each address writes only its own bit
    for (int k = 0; k < NB; k++) begin
      step(1'b1, SW'(k), 1'b0, 1'b1, "R1");
      step(1'b0, SW'(k), 1'b1, 1'b1, "R1");
      check("R1", latchOut, NB'(1) << k);
      step(1'b0, SW'(k), 1'b0, 1'b1, "R1");
    end

    // R4: last enabled-cycle data kept on release
    step(1'b0, 3'd3, 1'b0, 1'b1, "R4");
    step(1'b1, 3'd3, 1'b0, 1'b1, "R4");
    step(1'b0, 3'd6, 1'b1, 1'b1, "R4");
    check("R4", latchOut[3], 1'b1);

    // R5: address and data wander while held
    for (int k = 0; k < 16; k++)
      step(1'($urandom), SW'($urandom), 1'b1, 1'b1, "R5");

    // R7: decoder for every address and both data values, then hold
    for (int k = 0; k < NB; k++) begin
      step(1'b1, SW'(k), 1'b0, 1'b0, "R7");
      step(1'b0, SW'(k), 1'b1, 1'b1, "R7");
      check("R7", latchOut, NB'(1) << k);
      step(1'b0, SW'(k), 1'b0, 1'b0, "R7");
    end

    // R6: wipe after fill, then hold
    for (int k = 0; k < NB; k++) step(1'b1, SW'(k), 1'b0, 1'b1, "R2");
    step(1'b1, 3'd0, 1'b1, 1'b0, "R6");
    step(1'b1, 3'd7, 1'b1, 1'b1, "R6");
    check("R6", latchOut, '0);

    // Random mix across all four modes
    for (int k = 0; k < 600; k++)
      step(1'($urandom), SW'($urandom), 1'($urandom), 1'(($urandom % 4) != 0));

    // R8: reset mid-run clears a filled register
    for (int k = 0; k < NB; k++) step(1'b1, SW'(k), 1'b0, 1'b1, "R3");
    @(negedge clk); rst = 1'b1; enableN = 1'b1; clearN = 1'b1;
    @(posedge clk); modelQ = '0;
    step(1'b1, 3'd2, 1'b1, 1'b1, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule